// File: doc/BRIEF.md
# Multiplexed Rotary Encoder Scanner

This block reads eight push-button rotary encoders through a shared wiring matrix. Each encoder has its own drive line, and all three contacts of that encoder (phase A, phase B and the push switch) are tied to it. Contacts of the same kind on all encoders share one sense line, which a pull-up holds high. A closed contact pulls its sense line low only while the drive line of its encoder is grounded. At rest the block grounds every drive line and does nothing else, so the board sees no switching noise until a sense line falls.

A falling sense line starts a three-step halving search. Each step keeps only the upper half of the remaining candidate range grounded and releases every other line. After a settle time the block samples the sense lines. If a line is still low, the encoder lies in the grounded half. If every line has returned high, the encoder lies in the released half. Once the encoder is found, the block grounds that drive line alone. It then debounces the three contacts with counters and reports rotation steps and button changes as one-cycle events tagged with the encoder number. The focus stays on that encoder while its contacts keep changing. After a quiet interval the block goes back to grounding every line and waits for the next edge.

Top module: `mux_enc_scanner`

## Requirements
- R1: After reset, and whenever the block is at rest, `drive_low_o` is 8'hFF (every encoder grounded) and no event flag is high.
- R2: While at rest, a high-to-low change on any bit of `sense_ni` starts a search. The first search pattern is 8'hF0: encoders 4 to 7 grounded and 0 to 3 released.
- R3: Each search step holds its pattern for exactly SETTLE_CYC clocks (default 16) and then samples. If any sense line is low, the grounded half is kept. If all are high, the released half is kept. The range goes from 8 to 4 to 2 to 1 encoders, and the last one left is the located index.
- R4: While focused, `drive_low_o` is one-hot at the located index.
- R5: A contact change is accepted only after DEB_N consecutive synchronized samples (default 8) differ from the accepted state. A pulse of DEB_N-1 samples or fewer produces no event.
- R6: Let a and b be 1 when phase A and phase B are closed, and let pos = {b, a^b}. A change of +1 mod 4 in pos raises `step_up_o`. A change of -1 mod 4 raises `step_down_o`. A change of 2 produces no event. Closing A, closing B, opening A, then opening B gives four up steps. The reverse order gives four down steps.
- R7: An accepted close of the switch contact raises `btn_press_o`, and an accepted open raises `btn_release_o`.
- R8: Every flag is high for one clock. `evt_valid_o` is high in exactly the cycles where a flag is high, and `evt_index_o` then gives the focused encoder.
- R9: A contact closing on the focused encoder before the timeout runs out starts no search. The drive pattern stays one-hot, and the event is still reported.
- R10: Once all three contacts of the focused encoder have read open for TIMEOUT_CYC clocks (default 512), `drive_low_o` returns to 8'hFF. Contacts of other encoders are not seen while the focus holds. If one of them is still closed afterwards, a new search finds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sense_ni | input | 3 | Shared sense lines, active low: bit 0 phase A, bit 1 phase B, bit 2 switch |
| drive_low_o | output | 8 | Bit i high grounds encoder i's drive line; low releases it |
| evt_valid_o | output | 1 | One-cycle strobe for any event |
| evt_index_o | output | 3 | Encoder the event belongs to |
| step_up_o | output | 1 | One rotation step, up direction |
| step_down_o | output | 1 | One rotation step, down direction |
| btn_press_o | output | 1 | Push switch became closed |
| btn_release_o | output | 1 | Push switch became open |

## Verification
A drive pattern changes on the clock after the state that selects it. A contact change reaches the events after two synchronizer clocks, DEB_N debounce samples and one decode register, about 11 clocks in all. A first touch also pays for three settle windows, so its event is due at most about 62 clocks after the contact closes. The bench model queues each expected event in order and compares it with the design on every clock at the falling edge. It leaves 100 clocks before it requires the queue to be empty, and any event with no entry waiting for it is a failure. It logs each drive pattern change with the number of clocks the pattern is held, so the search path and the settle length are checked exactly. The timeout is checked on both sides of its expiry, 20 to 60 clocks away from the nominal edge.

// File: rtl/enc_scan_pkg.sv
package enc_scan_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEARCH, ST_TRACK} scan_state_e;
  localparam int CT_A  = 0;
  localparam int CT_B  = 1;
  localparam int CT_SW = 2;
  localparam int N_CT  = 3;
endpackage

// File: rtl/enc_debounce.sv
module enc_debounce #(
  parameter int DEB_N = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic raw_i,
  output logic stable_o
);
  localparam int CW = $clog2(DEB_N);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stable_o <= 1'b0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      stable_o <= 1'b0;
      cnt_q    <= '0;
    end else if (raw_i != stable_o) begin
      if (cnt_q == CW'(DEB_N - 1)) begin
        stable_o <= raw_i;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/enc_quad_decode.sv
module enc_quad_decode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic a_i,
  input  logic b_i,
  input  logic sw_i,
  output logic up_o,
  output logic dn_o,
  output logic press_o,
  output logic release_o
);
  logic a_q, b_q, sw_q;
  logic [1:0] pos_new, pos_old, delta;

  // Gray position: {b, a^b} walks 0..3 in the up direction
  assign pos_new = {b_i, a_i ^ b_i};
  assign pos_old = {b_q, a_q ^ b_q};
  assign delta   = pos_new - pos_old;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {a_q, b_q, sw_q} <= '0;
      {up_o, dn_o, press_o, release_o} <= '0;
    end else if (clr_i) begin
      {a_q, b_q, sw_q} <= '0;
      {up_o, dn_o, press_o, release_o} <= '0;
    end else begin
      a_q       <= a_i;
      b_q       <= b_i;
      sw_q      <= sw_i;
      up_o      <= (delta == 2'd1);
      dn_o      <= (delta == 2'd3);
      press_o   <= sw_i & ~sw_q;
      release_o <= ~sw_i & sw_q;
    end
  end
endmodule

// File: rtl/enc_search_ctrl.sv
module enc_search_ctrl
  import enc_scan_pkg::*;
#(
  parameter int N_ENC       = 8,
  parameter int SETTLE_CYC  = 16,
  parameter int TIMEOUT_CYC = 512,
  localparam int IDX_W      = $clog2(N_ENC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CT-1:0]  sense_i,
  output logic [N_ENC-1:0] drive_low_o,
  output logic             track_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int ST_W = $clog2(SETTLE_CYC);
  localparam int TO_W = $clog2(TIMEOUT_CYC);

  scan_state_e     state_q;
  logic [IDX_W-1:0] lo_q, lvl_q;
  logic [ST_W-1:0]  settle_q;
  logic [TO_W-1:0]  idle_q;
  logic [N_CT-1:0]  sense_prev_q;
  logic             fall, any_low;
  int               half;

  assign fall    = |(sense_prev_q & ~sense_i);
  assign any_low = ~&sense_i;
  assign track_o = (state_q == ST_TRACK);
  assign idx_o   = lo_q;

  always_comb begin
    half        = N_ENC >> (int'(lvl_q) + 1);
    drive_low_o = '0;
    case (state_q)
      ST_IDLE:   drive_low_o = '1;
      ST_SEARCH: begin
        // ground only the upper half of the live range
        for (int i = 0; i < N_ENC; i++)
          drive_low_o[i] = (i >= int'(lo_q) + half) && (i < int'(lo_q) + 2 * half);
      end
      default:   drive_low_o[lo_q] = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      lo_q         <= '0;
      lvl_q        <= '0;
      settle_q     <= '0;
      idle_q       <= '0;
      sense_prev_q <= '1;
    end else begin
      sense_prev_q <= sense_i;
      case (state_q)
        ST_IDLE: if (fall) begin
          state_q  <= ST_SEARCH;
          lo_q     <= '0;
          lvl_q    <= '0;
          settle_q <= '0;
        end
        ST_SEARCH: begin
          if (settle_q == ST_W'(SETTLE_CYC - 1)) begin
            settle_q <= '0;
            if (any_low) lo_q <= lo_q + IDX_W'(half);
            if (lvl_q == IDX_W'(IDX_W - 1)) begin
              state_q <= ST_TRACK;
              idle_q  <= '0;
            end else begin
              lvl_q <= lvl_q + 1'b1;
            end
          end else begin
            settle_q <= settle_q + 1'b1;
          end
        end
        default: begin
          if (any_low)                             idle_q  <= '0;
          else if (idle_q == TO_W'(TIMEOUT_CYC - 1)) state_q <= ST_IDLE;
          else                                     idle_q  <= idle_q + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/mux_enc_scanner.sv
module mux_enc_scanner
  import enc_scan_pkg::*;
#(
  parameter int N_ENC       = 8,
  parameter int SETTLE_CYC  = 16,
  parameter int DEB_N       = 8,
  parameter int TIMEOUT_CYC = 512,
  localparam int IDX_W      = $clog2(N_ENC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       sense_ni,
  output logic [N_ENC-1:0] drive_low_o,
  output logic             evt_valid_o,
  output logic [IDX_W-1:0] evt_index_o,
  output logic             step_up_o,
  output logic             step_down_o,
  output logic             btn_press_o,
  output logic             btn_release_o
);
  logic [N_CT-1:0] sync1_q, sync2_q, stable;
  logic            track;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '1;
      sync2_q <= '1;
    end else begin
      sync1_q <= sense_ni;
      sync2_q <= sync1_q;
    end
  end

  enc_search_ctrl #(
    .N_ENC(N_ENC), .SETTLE_CYC(SETTLE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) i_ctrl (
    .clk_i, .rst_ni,
    .sense_i    (sync2_q),
    .drive_low_o(drive_low_o),
    .track_o    (track),
    .idx_o      (evt_index_o)
  );

  for (genvar c = 0; c < N_CT; c++) begin : g_deb
    enc_debounce #(.DEB_N(DEB_N)) i_deb (
      .clk_i, .rst_ni,
      .clr_i   (~track),
      .raw_i   (~sync2_q[c]),
      .stable_o(stable[c])
    );
  end

  enc_quad_decode i_dec (
    .clk_i, .rst_ni,
    .clr_i    (~track),
    .a_i      (stable[CT_A]),
    .b_i      (stable[CT_B]),
    .sw_i     (stable[CT_SW]),
    .up_o     (step_up_o),
    .dn_o     (step_down_o),
    .press_o  (btn_press_o),
    .release_o(btn_release_o)
  );

  assign evt_valid_o = step_up_o | step_down_o | btn_press_o | btn_release_o;
endmodule

// File: rtl/mux_enc_scanner_chk.sv
module mux_enc_scanner_chk #(
  parameter int N_ENC = 8,
  parameter int IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_ENC-1:0] drive_low_o,
  input logic             evt_valid_o,
  input logic [IDX_W-1:0] evt_index_o,
  input logic             step_up_o,
  input logic             step_down_o,
  input logic             btn_press_o,
  input logic             btn_release_o
);
  localparam logic [N_ENC-1:0] UPPER = {{(N_ENC/2){1'b1}}, {(N_ENC/2){1'b0}}};

  assert_leave_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_low_o == '1) |=> (drive_low_o == '1) || (drive_low_o == UPPER));

  assert_drive_shape_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(drive_low_o) == N_ENC) || ($countones(drive_low_o) == N_ENC/2) ||
    ($countones(drive_low_o) == N_ENC/4) || ($countones(drive_low_o) == 1));

  assert_dir_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_up_o && step_down_o));

  assert_press_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    btn_press_o |=> !btn_press_o);

  assert_release_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    btn_release_o |=> !btn_release_o);

  assert_evt_focus_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> ($countones(drive_low_o) == 1) && drive_low_o[evt_index_o]);

  assert_focus_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |=> $stable(drive_low_o));
endmodule

bind mux_enc_scanner mux_enc_scanner_chk #(.N_ENC(N_ENC), .IDX_W(IDX_W)) i_chk (
  .clk_i, .rst_ni, .drive_low_o, .evt_valid_o, .evt_index_o,
  .step_up_o, .step_down_o, .btn_press_o, .btn_release_o
);

// File: tb/test_mux_enc_scanner.sv
`timescale 1ns/1ps
module test_mux_enc_scanner;
  localparam int SETTLE  = 16;
  localparam int DEB     = 8;
  localparam int TIMEOUT = 512;
  localparam int K_UP = 0, K_DN = 1, K_PR = 2, K_RL = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sense_n;
  logic [7:0] drive_low;
  logic       evt_valid, step_up, step_dn, press, rel;
  logic [2:0] evt_idx;
  logic [2:0] closed [8];   // per encoder: bit0 A, bit1 B, bit2 switch

  int checks = 0;
  int errors = 0;
  int exp_q[$];             // idx*4 + kind
  logic [7:0] drv_log[$];
  int         run_len[$];
  logic [7:0] drv_last;

  always #2 clk = ~clk;

  // behavioural pull-up: a line is low if any grounded encoder closes that contact
  always_comb begin
    for (int c = 0; c < 3; c++) begin
      sense_n[c] = 1'b1;
      for (int e = 0; e < 8; e++)
        if (drive_low[e] && closed[e][c]) sense_n[c] = 1'b0;
    end
  end

  mux_enc_scanner i_mux_enc_scanner (
    .clk_i(clk), .rst_ni(rst_n), .sense_ni(sense_n), .drive_low_o(drive_low),
    .evt_valid_o(evt_valid), .evt_index_o(evt_idx), .step_up_o(step_up),
    .step_down_o(step_dn), .btn_press_o(press), .btn_release_o(rel)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // event monitor, every clock at the falling edge
  always @(negedge clk) if (rst_n) begin
    if (drive_low != drv_last) begin
      drv_log.push_back(drive_low);
      run_len.push_back(1);
      drv_last = drive_low;
    end else if (run_len.size() > 0) begin
      run_len[run_len.size()-1]++;
    end
    if (evt_valid) begin
      int kind, got;
      kind = step_up ? K_UP : step_dn ? K_DN : press ? K_PR : K_RL;
      check($countones({step_up, step_dn, press, rel}) == 1, "R8 single flag",
            int'({step_up, step_dn, press, rel}), 1);
      got = int'(evt_idx) * 4 + kind;
      if (exp_q.size() == 0) check(0, "R5/R8 unexpected event", got, -1);
      else check(got == exp_q.pop_front(), "R6/R7 event idx*4+kind", got, got);
    end else begin
      check({step_up, step_dn, press, rel} == 4'b0, "R8 flag without strobe",
            int'({step_up, step_dn, press, rel}), 0);
      checks--;  // bookkeeping guard, not a counted check
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_log();
    drv_log.delete();
    run_len.delete();
    drv_last = drive_low;
  endtask

  task automatic set_ct(input int e, input int c, input logic v);
    @(negedge clk);
    closed[e][c] = v;
  endtask

  task automatic check_log(input logic [7:0] exp[$], input string tag);
    check(drv_log.size() == exp.size(), {tag, " pattern count"}, drv_log.size(), exp.size());
    for (int i = 0; i < exp.size() && i < drv_log.size(); i++)
      check(drv_log[i] == exp[i], {tag, " pattern"}, drv_log[i], exp[i]);
  endtask

  task automatic drained(input string tag);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic tap(input int e);   // clean press and release of one encoder
    exp_q.push_back(e * 4 + K_PR);
    set_ct(e, 2, 1'b1); wait_clk(100);
    exp_q.push_back(e * 4 + K_RL);
    set_ct(e, 2, 1'b0); wait_clk(40);
    drained("R7 tap events");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    for (int e = 0; e < 8; e++) closed[e] = 3'b000;
    drv_last = 8'hFF;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    // R1 rest state
    check(drive_low == 8'hFF, "R1 drive at rest", drive_low, 8'hFF);
    check(!evt_valid, "R1 no event at rest", evt_valid, 0);

    // encoder 7: search path, settle length, focus, timeout
    clear_log();
    exp_q.push_back(7 * 4 + K_PR);
    set_ct(7, 2, 1'b1); wait_clk(100);
    check_log('{8'hF0, 8'hC0, 8'h80}, "R2/R3 enc7");
    check(run_len.size() > 0 && run_len[0] == SETTLE, "R3 settle length",
          run_len.size() > 0 ? run_len[0] : -1, SETTLE);
    check(drive_low == 8'h80, "R4 focus enc7", drive_low, 8'h80);
    exp_q.push_back(7 * 4 + K_RL);
    set_ct(7, 2, 1'b0); wait_clk(40);
    drained("R7 enc7 events");
    wait_clk(TIMEOUT - 60);
    check(drive_low == 8'h80, "R10 focus before timeout", drive_low, 8'h80);
    wait_clk(80);
    check(drive_low == 8'hFF, "R10 rest after timeout", drive_low, 8'hFF);

    // encoder 0: every step goes to the released half
    clear_log();
    tap(0);
    check_log('{8'hF0, 8'h0C, 8'h02, 8'h01}, "R3 enc0");
    wait_clk(TIMEOUT + 60);

    // encoder 2: four steps up
    clear_log();
    for (int k = 0; k < 4; k++) exp_q.push_back(2 * 4 + K_UP);
    set_ct(2, 0, 1'b1); wait_clk(100);
    set_ct(2, 1, 1'b1); wait_clk(40);
    set_ct(2, 0, 1'b0); wait_clk(40);
    set_ct(2, 1, 1'b0); wait_clk(40);
    drained("R6 up steps enc2");
    check_log('{8'hF0, 8'h0C, 8'h08, 8'h04}, "R3 enc2");
    wait_clk(TIMEOUT + 60);

    // encoder 5: four steps down
    for (int k = 0; k < 4; k++) exp_q.push_back(5 * 4 + K_DN);
    set_ct(5, 1, 1'b1); wait_clk(100);
    set_ct(5, 0, 1'b1); wait_clk(40);
    set_ct(5, 1, 1'b0); wait_clk(40);
    set_ct(5, 0, 1'b0); wait_clk(40);
    drained("R6 down steps enc5");
    check(drive_low == 8'h20, "R4 focus enc5", drive_low, 8'h20);
    wait_clk(TIMEOUT + 60);

    // encoder 4: bounce rejection and the accept boundary
    tap(4);
    for (int k = 0; k < 5; k++) begin
      set_ct(4, 2, 1'b1); wait_clk(2);
      set_ct(4, 2, 1'b0); wait_clk(2);
    end
    set_ct(4, 2, 1'b1); wait_clk(DEB - 2);   // DEB-1 samples closed
    set_ct(4, 2, 1'b0); wait_clk(40);
    check(exp_q.size() == 0 && drive_low == 8'h10, "R5 short pulses ignored", drive_low, 8'h10);
    exp_q.push_back(4 * 4 + K_PR);
    exp_q.push_back(4 * 4 + K_RL);
    set_ct(4, 2, 1'b1); wait_clk(DEB + 2);
    set_ct(4, 2, 1'b0); wait_clk(40);
    drained("R5 pulse of DEB+2 accepted");
    wait_clk(TIMEOUT + 60);

    // encoder 3: re-press inside the timeout skips the search
    tap(3);
    clear_log();
    tap(3);
    check(drv_log.size() == 0, "R9 no search inside timeout", drv_log.size(), 0);
    check(drive_low == 8'h08, "R9 focus kept", drive_low, 8'h08);

    // encoder 6 closes while 3 holds focus: hidden until timeout, then found
    set_ct(6, 2, 1'b1); wait_clk(100);
    check(drive_low == 8'h08, "R10 other encoder unseen", drive_low, 8'h08);
    exp_q.push_back(6 * 4 + K_PR);
    wait_clk(TIMEOUT + 100);
    drained("R10 later search finds enc6");
    check(drive_low == 8'h40, "R10 focus enc6", drive_low, 8'h40);
    exp_q.push_back(6 * 4 + K_RL);
    set_ct(6, 2, 1'b0); wait_clk(TIMEOUT + 60);
    drained("R7 enc6 release");
    check(drive_low == 8'hFF, "R1 back at rest", drive_low, 8'hFF);
    finish_run();
  end
endmodule